// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Oscillating Self-Test

This block forms the product of two signed 8-bit operands and can add it to a running total kept in a 19-bit result register. It is meant for a signal-processing datapath that streams one operand pair per clock. Operands are captured on the falling clock edge. The result for the captured pair appears at the next falling edge, while the following pair is captured. The 16-bit product is widened by three guard bits, so that a sum of several products fits before the total wraps.

The partial products are summed with a sign-bias method. Each partial-product bit that pairs exactly one operand sign bit with a magnitude bit is inverted. A fixed correction word is added to the array, and the total is taken modulo 2^19. A mode input selects whether the previous result is fed back into the adder or whether zero is added. Two clear inputs empty the operand latches and the result latch independently.

A self-test mode turns the unit into a ring. The top bit of the adder output drives the sign bit of the Y operand latch, and the top bit of the stored result drives the accumulate select. When started with X = -1, Y = 43 and a cleared result, the output alternates between -43 and 42 on every clock. The rate at which it alternates gives the delay through the multiplier.

Top module: `sbias_mac`

## Requirements
- R1: Both operand latches and the result latch change only on the falling edge of `clk`. The result for an operand pair captured at one falling edge appears at the next falling edge.
- R2: With accumulation off, `result` equals the 16-bit signed product of the captured operands, sign-extended to 19 bits.
- R3: The product is exact for every pair of 8-bit two's-complement operands, including -128 x -128 = 16384 and -128 x 127 = -16256.
- R4: With `acc_mode` = 1, the new result is the old result plus the new product, modulo 2^19. It wraps with no saturation: thirty-two accumulations of 16384 bring the total back to 0.
- R5: With `acc_mode` = 0, zero is added in place of the old result.
- R6: `clr_in` = 1 at a falling edge loads zero into both operand latches in place of `x_in` and `y_in`.
- R7: `clr_out` = 1 at a falling edge loads zero into the result latch, taking priority over the product and over accumulation.
- R8: With `self_test` = 1, bit 7 of the Y operand latch is loaded from bit 18 of the adder output, and `y_in[7]` is ignored. Bits 6..0 still come from `y_in`.
- R9: With `self_test` = 1, accumulation is controlled by bit 18 of the stored result, and `acc_mode` is ignored.
- R10: The self-test is started by holding X = -1 and Y[6:0] = 43 with the result cleared. The result then reads -43 (19'h7FFD5), 42, -43, 42, and so on, one value per clock.
- R11: `rst_n` = 0 clears the operand latches and the result at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_in | input | 1 | Load zero into both operand latches |
| clr_out | input | 1 | Load zero into the result latch |
| acc_mode | input | 1 | 1 = add the previous result to the product |
| self_test | input | 1 | 1 = enable the feedback test loop |
| x_in | input | 8 | X operand, two's complement |
| y_in | input | 8 | Y operand, two's complement |
| result | output | 19 | Latched product or accumulated total |

## Verification
Two functions can act at the same falling edge, and the bench provokes each pairing on purpose. In the first, `clr_out` is raised while `acc_mode` is 1 and a non-zero product is pending; the result must read zero, not the accumulated sum. In the second, the self-test loop is started with `y_in[7]` and `acc_mode` both driven to the wrong values, so any leak of either input past its feedback multiplexer changes the alternating -43/42 sequence. Both cases are judged against a bench reference of the latches, and against fixed expected values at the points the requirements name.

// File: rtl/sbias_mac_pkg.sv
package sbias_mac_pkg;

    localparam int unsigned DEF_XW = 8;
    localparam int unsigned DEF_YW = 8;
    localparam int unsigned DEF_GW = 3;

    // Correction word for sign-bias summation of an xw-by-yw signed array,
    // reduced to rw bits: 2^(xw-1) + 2^(yw-1) - 2^(xw+yw-1)
    function automatic longint unsigned bias_const(int xw, int yw, int rw);
        longint unsigned mask;
        longint unsigned v;
        mask = (64'd1 << rw) - 64'd1;
        v = (64'd1 << (xw - 1)) + (64'd1 << (yw - 1)) - (64'd1 << (xw + yw - 1));
        return v & mask;
    endfunction

endpackage

// File: rtl/sbias_pp_gen.sv
module sbias_pp_gen #(
    parameter int unsigned XW = 8,
    parameter int unsigned YW = 8,
    parameter int unsigned RW = 19
) (
    input  logic [XW-1:0]          x,
    input  logic [YW-1:0]          y,
    output logic [YW-1:0][RW-1:0]  rows
);

    // One row per Y bit, already shifted to its weight. Bits pairing exactly
    // one sign bit are inverted; the sign-by-sign bit stays true.
    for (genvar i = 0; i < YW; i++) begin : g_row
        for (genvar b = 0; b < RW; b++) begin : g_bit
            if (b >= i && b < i + XW) begin : g_pp
                localparam int J = b - i;
                localparam bit INV = ((i == YW - 1) != (J == XW - 1));
                if (INV) begin : g_inv
                    assign rows[i][b] = ~(x[J] & y[i]);
                end else begin : g_true
                    assign rows[i][b] = x[J] & y[i];
                end
            end else begin : g_zero
                assign rows[i][b] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/sbias_sum_tree.sv
module sbias_sum_tree #(
    parameter int unsigned                 NROWS = 8,
    parameter int unsigned                 RW    = 19,
    parameter logic [RW-1:0]               BIAS  = '0
) (
    input  logic [NROWS-1:0][RW-1:0] rows,
    input  logic [RW-1:0]            addend,
    output logic [RW-1:0]            sum
);

    localparam int unsigned NLEAF = NROWS + 2;
    localparam int unsigned NLVL  = $clog2(NLEAF);
    localparam int unsigned NPAD  = 1 << NLVL;

    // Binary tree of adders; level 0 holds rows, the bias word and the feedback term.
    logic [NLVL:0][NPAD-1:0][RW-1:0] lvl;

    for (genvar k = 0; k < NPAD; k++) begin : g_leaf
        if (k < NROWS) begin : g_row
            assign lvl[0][k] = rows[k];
        end else if (k == NROWS) begin : g_bias
            assign lvl[0][k] = BIAS;
        end else if (k == NROWS + 1) begin : g_add
            assign lvl[0][k] = addend;
        end else begin : g_pad
            assign lvl[0][k] = '0;
        end
    end

    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        for (genvar k = 0; k < NPAD; k++) begin : g_node
            if (k < (NPAD >> (l + 1))) begin : g_add
                assign lvl[l+1][k] = lvl[l][2*k] + lvl[l][2*k+1];
            end else begin : g_idle
                assign lvl[l+1][k] = '0;
            end
        end
    end

    assign sum = lvl[NLVL][0];

endmodule

// File: rtl/sbias_mac.sv
module sbias_mac
    import sbias_mac_pkg::*;
#(
    parameter int unsigned XW = DEF_XW,
    parameter int unsigned YW = DEF_YW,
    parameter int unsigned GW = DEF_GW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_in,
    input  logic          clr_out,
    input  logic          acc_mode,
    input  logic          self_test,
    input  logic [XW-1:0] x_in,
    input  logic [YW-1:0] y_in,
    output logic [XW+YW+GW-1:0] result
);

    localparam int unsigned PW = XW + YW;
    localparam int unsigned RW = PW + GW;
    localparam logic [RW-1:0] BIAS = RW'(bias_const(XW, YW, RW));

    typedef struct packed {
        logic [XW-1:0] x;
        logic [YW-1:0] y;
        logic [RW-1:0] res;
    } mac_state_t;

    mac_state_t st_d, st_q;

    logic [YW-1:0][RW-1:0] rows;
    logic [RW-1:0]         fb_term;
    logic [RW-1:0]         sum;
    logic                  acc_sel;
    logic [YW-1:0]         y_next;

    sbias_pp_gen #(.XW(XW), .YW(YW), .RW(RW)) pp_i (
        .x    (st_q.x),
        .y    (st_q.y),
        .rows (rows)
    );

    sbias_sum_tree #(.NROWS(YW), .RW(RW), .BIAS(BIAS)) tree_i (
        .rows   (rows),
        .addend (fb_term),
        .sum    (sum)
    );

    always_comb begin
        // accumulate select: from the stored result's top bit during self-test
        acc_sel = self_test ? st_q.res[RW-1] : acc_mode;
        fb_term = acc_sel ? st_q.res : '0;

        y_next = y_in;
        if (self_test) begin
            y_next[YW-1] = sum[RW-1];
        end

        st_d     = st_q;
        st_d.x   = clr_in  ? '0 : x_in;
        st_d.y   = clr_in  ? '0 : y_next;
        st_d.res = clr_out ? '0 : sum;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = st_q.res;

endmodule

// File: rtl/sbias_mac_chk.sv
module sbias_mac_chk #(
    parameter int unsigned XW = 8,
    parameter int unsigned YW = 8,
    parameter int unsigned GW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr_in,
    input logic          clr_out,
    input logic          acc_mode,
    input logic          self_test,
    input logic [XW-1:0] x_in,
    input logic [YW-1:0] y_in,
    input logic [XW+YW+GW-1:0] result
);

    localparam int unsigned RW = XW + YW + GW;

    function automatic logic [RW-1:0] sprod(logic [XW-1:0] a, logic [YW-1:0] b);
        logic [RW-1:0] ea;
        logic [RW-1:0] eb;
        ea = {{(RW-XW){a[XW-1]}}, a};
        eb = {{(RW-YW){b[YW-1]}}, b};
        return ea * eb;
    endfunction

    // R7: result clear wins over everything
    a_r7_clear_result: assert property (@(negedge clk) disable iff (!rst_n)
        clr_out |=> (result == '0));

    // R6: cleared operands give a zero product
    a_r6_clear_operands: assert property (@(negedge clk) disable iff (!rst_n)
        clr_in ##1 (!clr_out && !acc_mode && !self_test) |=> (result == '0));

    // R2: multiply-only result equals the signed product
    a_r2_product: assert property (@(negedge clk) disable iff (!rst_n)
        (!clr_in && !self_test) ##1 (!clr_out && !acc_mode && !self_test)
        |=> (result == sprod($past(x_in, 2), $past(y_in, 2))));

    // R4: accumulation adds the product to the previous total
    a_r4_accumulate: assert property (@(negedge clk) disable iff (!rst_n)
        (!clr_in && !self_test) ##1 (!clr_out && acc_mode && !self_test)
        |=> (result == RW'($past(result) + sprod($past(x_in, 2), $past(y_in, 2)))));

    // R11: asynchronous reset holds the result at zero
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r11_reset_zero: assert (result == '0);
        end
    end

endmodule

bind sbias_mac sbias_mac_chk #(.XW(XW), .YW(YW), .GW(GW)) chk_i (.*);

// File: tb/sbias_mac_tb_top.sv
`timescale 1ns/1ps
module sbias_mac_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_in = 1'b0;
    logic        clr_out = 1'b0;
    logic        acc_mode = 1'b0;
    logic        self_test = 1'b0;
    logic [7:0]  x_in = '0;
    logic [7:0]  y_in = '0;
    logic [18:0] result;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    // reference state
    logic [7:0]  mx = '0;
    logic [7:0]  my = '0;
    logic [18:0] mr = '0;

    always #4 clk = ~clk;

    sbias_mac dut_i (
        .clk(clk), .rst_n(rst_n), .clr_in(clr_in), .clr_out(clr_out),
        .acc_mode(acc_mode), .self_test(self_test),
        .x_in(x_in), .y_in(y_in), .result(result)
    );

    function automatic logic [18:0] sp(logic [7:0] a, logic [7:0] b);
        int p;
        p = $signed(a) * $signed(b);
        return 19'(p);
    endfunction

    task automatic check(string tag, logic [18:0] got, logic [18:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: result=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // one falling edge of the reference, then compare at the rising edge
    task automatic tick(string tag);
        logic        a;
        logic [18:0] s;
        logic [7:0]  ny;
        @(negedge clk);
        a  = self_test ? mr[18] : acc_mode;
        s  = sp(mx, my) + (a ? mr : 19'd0);
        ny = y_in;
        if (self_test) ny[7] = s[18];
        mx = clr_in ? 8'd0 : x_in;
        my = clr_in ? 8'd0 : ny;
        mr = clr_out ? 19'd0 : s;
        @(posedge clk);
        check(tag, result, mr);
    endtask

    task automatic drive(logic ci, logic co, logic am, logic st, logic [7:0] x, logic [7:0] y);
        clr_in = ci; clr_out = co; acc_mode = am; self_test = st; x_in = x; y_in = y;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset", result, 19'd0);
        @(posedge clk);
        rst_n = 1'b1;

        // R1: result lags the operand latch by one falling edge
        drive(0, 0, 0, 0, 8'd3, 8'd5);
        tick("R1");
        check("R1 not yet", result, 19'd0);
        drive(0, 0, 0, 0, 8'd0, 8'd0);
        tick("R1");
        check("R1 product", result, 19'd15);

        // R2/R3: every operand pair, multiply only
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                drive(0, 0, 0, 0, 8'(a), 8'(b));
                tick("R2 R3 sweep");
            end
        end
        drive(0, 0, 0, 0, 8'h80, 8'h80);
        tick("R3");
        drive(0, 0, 0, 0, 8'h80, 8'h7F);
        tick("R3");
        check("R3 -128*-128", result, 19'd16384);
        tick("R3");
        check("R3 -128*127", result, 19'(-16256));

        // R4: wrap after thirty-two accumulations of 16384
        drive(0, 1, 0, 0, 8'h80, 8'h80);
        tick("R7");
        drive(0, 0, 1, 0, 8'h80, 8'h80);
        for (int k = 0; k < 32; k++) tick("R4 wrap");
        check("R4 wrap", result, 19'd0);

        // R5: accumulate off adds zero
        drive(0, 0, 0, 0, 8'd2, 8'd3);
        tick("R5");
        tick("R5");
        check("R5 no add", result, 19'd6);

        // R6: operand clear beats loading
        drive(1, 0, 0, 0, 8'd5, 8'd5);
        tick("R6");
        drive(0, 0, 0, 0, 8'd5, 8'd5);
        tick("R6");
        check("R6 cleared operands", result, 19'd0);

        // R7 with accumulation pending
        drive(0, 0, 1, 0, 8'd9, 8'd9);
        tick("R7");
        drive(0, 1, 1, 0, 8'd9, 8'd9);
        tick("R7");
        check("R7 clear over acc", result, 19'd0);

        // R8/R9/R10: self-test start with misleading y_in[7] and acc_mode
        drive(0, 1, 0, 0, 8'hFF, 8'd43);
        tick("R10 setup");
        drive(0, 0, 1, 1, 8'hFF, 8'd171);
        tick("R8 R9");
        check("R10 first", result, 19'h7FFD5);
        tick("R8 R9");
        check("R10 second", result, 19'd42);
        tick("R8 R9");
        check("R10 third", result, 19'h7FFD5);
        drive(0, 0, 0, 1, 8'hFF, 8'd43);
        tick("R8 R9");
        check("R10 fourth", result, 19'd42);
        tick("R9");

        // random mix of all controls
        for (int k = 0; k < 3000; k++) begin
            drive(($urandom % 16) == 0, ($urandom % 16) == 0, $urandom % 2,
                  ($urandom % 8) == 0, 8'($urandom), 8'($urandom));
            tick("R4 R5 R8 R9 random");
        end

        // R11: asynchronous reset mid-run
        drive(0, 0, 1, 0, 8'd77, 8'd91);
        tick("R4");
        tick("R4");
        #2;
        rst_n = 1'b0;
        #1;
        check("R11 async", result, 19'd0);
        mx = '0; my = '0; mr = '0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        drive(0, 0, 0, 0, 8'd0, 8'd0);
        tick("R11 after");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule